// File: doc/BRIEF.md
# AC-link input frame decoder

This block sits on the controller side of an AC'97-style serial audio link and decodes the frames that the codec sends toward the controller. It samples one serial bit per bit-clock cycle. A rising edge on the frame marker sets its alignment. It cuts each 256-bit frame into a 16-bit tag slot followed by twelve 20-bit data slots, all sent MSB first.

From the tag it takes the codec-ready indication and the per-slot valid marks. It uses them to decide which slot contents are passed on.

- Register-read results (echoed index plus 16-bit data) leave as one strobe.
- Left and right 18-bit record samples each leave on their own strobe.
- The two active-low request bits carried in slot 1 become per-frame "supply a playback sample next frame" flags for the transmit side. This gives variable-rate flow control.
- The reserved slots 5 to 12 are ignored.

Top module: `aclink_rx_decoder`

## Requirements
- R1: A synchronous reset clears every output to zero. After reset, serial bits are ignored until the frame marker `sync_i` is seen rising.
- R2: The bit sampled in the cycle where `sync_i` is first seen high is tag bit 15. A frame is a 16-bit tag followed by twelve 20-bit slots, each sent MSB first, for 256 bits in total.
- R3: `codec_ready_o` equals tag bit 15 of the latest frame (1 = ready). It is updated in the cycle after the last tag bit.
- R4: When tag bits 15, 14 and 13 are all 1, `rd_stb_o` pulses for one cycle in the cycle after the last bit of slot 2. At the same time `rd_addr_o` carries slot 1 bits 18:12 and `rd_data_o` carries slot 2 bits 19:4.
- R5: No read strobe is produced when codec-ready (tag bit 15) is 0 or when either tag bit 14 or tag bit 13 is 0.
- R6: When tag bit 12 is 1, `left_stb_o` pulses for one cycle in the cycle after the last bit of slot 3, with `left_pcm_o` set to slot 3 bits 19:2. When tag bit 12 is 0, no left strobe is produced and `left_pcm_o` holds its value.
- R7: When tag bit 11 is 1, `right_stb_o` pulses for one cycle in the cycle after the last bit of slot 4, with `right_pcm_o` set to slot 4 bits 19:2. When tag bit 11 is 0, no right strobe is produced and `right_pcm_o` holds its value.
- R8: Request flag update, when tag bit 14 is 1:
  - `req_left_o` becomes the inverse of slot 1 bit 11.
  - `req_right_o` becomes the inverse of slot 1 bit 10.
  - Both update in the cycle after the last bit of slot 1.
  - When tag bit 14 is 0, both flags become 0 at that point instead.
  - The flags change at no other time.
- R9: The contents of slots 5 to 12 cause no strobe and leave every output unchanged.
- R10: A rising edge of `sync_i` in the middle of a frame restarts alignment, and the bit sampled in that cycle becomes tag bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit is sampled per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | Frame marker; its rising edge marks the first tag bit |
| sdin_i | input | 1 | Serial input data from the codec |
| codec_ready_o | output | 1 | Codec-ready bit of the latest tag |
| rd_stb_o | output | 1 | One-cycle strobe: register-read result valid |
| rd_addr_o | output | 7 | Echoed register index of the read |
| rd_data_o | output | 16 | Register read data |
| left_stb_o | output | 1 | One-cycle strobe: new left record sample |
| left_pcm_o | output | 18 | Left record sample |
| right_stb_o | output | 1 | One-cycle strobe: new right record sample |
| right_pcm_o | output | 18 | Right record sample |
| req_left_o | output | 1 | Supply a left playback sample in the next output frame |
| req_right_o | output | 1 | Supply a right playback sample in the next output frame |

## Verification
Frames are sent with every valid mark set, with codec-ready cleared while the marks stay set, and with the slot 1 and slot 2 marks cleared one at a time. These frames separate the three-way read qualification from the single-mark gating of the sample strobes, and from the fallback of the request flags to "none". The request bit pairs 0/1 and 1/0 show whether each flag is inverted and kept on its own lane. The reserved slots carry all-ones and all-zeros fill, so any strobe they raise shows up as an unexpected item in the scoreboard. A truncated frame followed at once by a fresh marker separates true realignment from counting through to 256. A reset in mid-frame checks that stale state is cleared.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;

    localparam int TAG_W      = 16;
    localparam int SLOT_W     = 20;
    localparam int NUM_SLOTS  = 12;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1);
    localparam int ADDR_W     = 7;
    localparam int RDATA_W    = 16;
    localparam int PCM_W      = 18;
    localparam int NUM_TAGV   = 4;

    // bit positions inside a 20-bit slot word
    localparam int ADDR_LSB   = 12;
    localparam int REQ_L_BIT  = 11;
    localparam int REQ_R_BIT  = 10;
    localparam int RDATA_LSB  = SLOT_W - RDATA_W;
    localparam int PCM_LSB    = SLOT_W - PCM_W;

    typedef struct packed {
        logic                 ready;
        logic [NUM_TAGV-1:0]  tagv;      // [3]=slot1 .. [0]=slot4
        logic [ADDR_W-1:0]    addr_hold;
        logic                 req_l;
        logic                 req_r;
        logic                 rd_stb;
        logic [ADDR_W-1:0]    rd_addr;
        logic [RDATA_W-1:0]   rd_data;
        logic                 l_stb;
        logic [PCM_W-1:0]     l_pcm;
        logic                 r_stb;
        logic [PCM_W-1:0]     r_pcm;
    } rx_state_t;

endpackage

// File: rtl/acrx_frame_timer.sv
module acrx_frame_timer #(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12,
    localparam int SW       = $clog2(NUM_SLOTS + 1),
    localparam int BW       = $clog2(SLOT_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_i,
    output logic          bit_vld_o,
    output logic [SW-1:0] slot_o,
    output logic          slot_end_o
);

    typedef struct packed {
        logic          sync;
        logic          locked;
        logic [SW-1:0] slot;
        logic [BW-1:0] bitn;
    } tmr_t;

    tmr_t t_d, t_q;
    logic          sync_rise;
    logic [SW-1:0] cur_slot;
    logic [BW-1:0] cur_bit;

    always_comb begin
        t_d        = t_q;
        sync_rise  = sync_i & ~t_q.sync;
        bit_vld_o  = (sync_rise | t_q.locked) & ~rst;
        cur_slot   = sync_rise ? '0 : t_q.slot;
        cur_bit    = sync_rise ? '0 : t_q.bitn;
        slot_end_o = (cur_slot == '0) ? (cur_bit == BW'(TAG_W - 1))
                                      : (cur_bit == BW'(SLOT_W - 1));
        slot_o     = cur_slot;
        t_d.sync   = sync_i;
        t_d.locked = bit_vld_o;
        if (bit_vld_o) begin
            if (slot_end_o) begin
                t_d.bitn = '0;
                t_d.slot = (cur_slot == SW'(NUM_SLOTS)) ? '0 : SW'(cur_slot + 1'b1);
            end else begin
                t_d.bitn = BW'(cur_bit + 1'b1);
                t_d.slot = cur_slot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    // R2: counters never leave the frame layout
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
        t_q.locked |-> (t_q.slot <= SW'(NUM_SLOTS) && t_q.bitn < BW'(SLOT_W)));

    // R2: the tag is followed by the first bit of slot 1
    assert_tag_span_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_vld_o && slot_o == '0 && slot_end_o) |=> (t_q.slot == SW'(1) && t_q.bitn == '0));

endmodule

// File: rtl/acrx_shift_in.sv
module acrx_shift_in #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         din_i,
    output logic [W-1:0] word_o
);

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        word_o = {sh_q[W-2:0], din_i};
        sh_d   = en_i ? word_o : sh_q;
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

endmodule

// File: rtl/aclink_rx_decoder.sv
module aclink_rx_decoder
    import aclink_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_i,
    input  logic               sdin_i,
    output logic               codec_ready_o,
    output logic               rd_stb_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    output logic [RDATA_W-1:0] rd_data_o,
    output logic               left_stb_o,
    output logic [PCM_W-1:0]   left_pcm_o,
    output logic               right_stb_o,
    output logic [PCM_W-1:0]   right_pcm_o,
    output logic               req_left_o,
    output logic               req_right_o
);

    logic                  bit_vld;
    logic [SLOT_IDX_W-1:0] slot_idx;
    logic                  slot_end;
    logic [SLOT_W-1:0]     word;
    logic                  s1_hit;
    rx_state_t             s_d, s_q;

    acrx_frame_timer #(
        .TAG_W     (TAG_W),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .sync_i     (sync_i),
        .bit_vld_o  (bit_vld),
        .slot_o     (slot_idx),
        .slot_end_o (slot_end)
    );

    acrx_shift_in #(
        .W (SLOT_W)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .en_i   (bit_vld),
        .din_i  (sdin_i),
        .word_o (word)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rd_stb = 1'b0;
        s_d.l_stb  = 1'b0;
        s_d.r_stb  = 1'b0;
        s1_hit     = bit_vld && slot_end && (slot_idx == SLOT_IDX_W'(1));
        if (bit_vld && slot_end) begin
            case (slot_idx)
                SLOT_IDX_W'(0): begin
                    s_d.ready = word[TAG_W-1];
                    s_d.tagv  = word[TAG_W-2 -: NUM_TAGV];
                end
                SLOT_IDX_W'(1): begin
                    if (s_q.tagv[3]) begin
                        s_d.addr_hold = word[ADDR_LSB +: ADDR_W];
                        s_d.req_l     = ~word[REQ_L_BIT];
                        s_d.req_r     = ~word[REQ_R_BIT];
                    end else begin
                        s_d.req_l = 1'b0;
                        s_d.req_r = 1'b0;
                    end
                end
                SLOT_IDX_W'(2): begin
                    if (s_q.ready && s_q.tagv[3] && s_q.tagv[2]) begin
                        s_d.rd_stb  = 1'b1;
                        s_d.rd_addr = s_q.addr_hold;
                        s_d.rd_data = word[RDATA_LSB +: RDATA_W];
                    end
                end
                SLOT_IDX_W'(3): begin
                    if (s_q.tagv[1]) begin
                        s_d.l_stb = 1'b1;
                        s_d.l_pcm = word[PCM_LSB +: PCM_W];
                    end
                end
                SLOT_IDX_W'(4): begin
                    if (s_q.tagv[0]) begin
                        s_d.r_stb = 1'b1;
                        s_d.r_pcm = word[PCM_LSB +: PCM_W];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign codec_ready_o = s_q.ready;
    assign rd_stb_o      = s_q.rd_stb;
    assign rd_addr_o     = s_q.rd_addr;
    assign rd_data_o     = s_q.rd_data;
    assign left_stb_o    = s_q.l_stb;
    assign left_pcm_o    = s_q.l_pcm;
    assign right_stb_o   = s_q.r_stb;
    assign right_pcm_o   = s_q.r_pcm;
    assign req_left_o    = s_q.req_l;
    assign req_right_o   = s_q.req_r;

    // R5: a read result never leaves while the codec reports not ready
    assert_rd_needs_ready_R5: assert property (@(posedge clk) disable iff (rst)
        rd_stb_o |-> codec_ready_o);

    // R9: slots end at different times, so strobes never coincide
    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stb_o, left_stb_o, right_stb_o}));

    // R6: left strobe lasts one cycle
    assert_left_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        left_stb_o |=> !left_stb_o);

    // R7: right strobe lasts one cycle
    assert_right_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        right_stb_o |=> !right_stb_o);

    // R8: request flags move only right after slot 1 closes
    assert_req_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(s1_hit) && !$past(rst)) |-> $stable({req_left_o, req_right_o}));

endmodule

// File: tb/aclink_rx_decoder_tb.sv
`timescale 1ns/1ps
module aclink_rx_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_i = 1'b0;
    logic        sdin_i = 1'b0;
    logic        codec_ready_o, rd_stb_o, left_stb_o, right_stb_o;
    logic        req_left_o, req_right_o;
    logic [6:0]  rd_addr_o;
    logic [15:0] rd_data_o;
    logic [17:0] left_pcm_o, right_pcm_o;

    always #2.5 clk = ~clk;

    aclink_rx_decoder u_dut (
        .clk           (clk),
        .rst           (rst),
        .sync_i        (sync_i),
        .sdin_i        (sdin_i),
        .codec_ready_o (codec_ready_o),
        .rd_stb_o      (rd_stb_o),
        .rd_addr_o     (rd_addr_o),
        .rd_data_o     (rd_data_o),
        .left_stb_o    (left_stb_o),
        .left_pcm_o    (left_pcm_o),
        .right_stb_o   (right_stb_o),
        .right_pcm_o   (right_pcm_o),
        .req_left_o    (req_left_o),
        .req_right_o   (req_right_o)
    );

    typedef struct packed {
        logic [1:0]  kind;   // 0 read, 1 left, 2 right
        logic [22:0] val;
    } exp_t;

    exp_t  exq[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    logic [17:0] exp_left  = '0;
    logic [17:0] exp_right = '0;

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic got(input logic [1:0] kind, input logic [22:0] val, input string rq);
        exp_t e;
        n_tests++;
        if (exq.size() == 0) begin
            n_fail++;
            $display("FAIL %s: actual unexpected strobe kind %0d val %h expected none", rq, kind, val);
        end else begin
            e = exq.pop_front();
            if (e.kind !== kind || e.val !== val) begin
                n_fail++;
                $display("FAIL %s: actual kind %0d val %h expected kind %0d val %h",
                         rq, kind, val, e.kind, e.val);
            end
        end
    endtask

    // monitor: pops the scoreboard as strobes appear (R4, R6, R7, R5, R9)
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_stb_o)    got(2'd0, {rd_addr_o, rd_data_o}, "R4");
            if (left_stb_o)  got(2'd1, {5'd0, left_pcm_o}, "R6");
            if (right_stb_o) got(2'd2, {5'd0, right_pcm_o}, "R7");
        end
    end

    function automatic logic [255:0] mk(input logic [15:0] tag, input logic [19:0] s1,
                                        input logic [19:0] s2, input logic [19:0] s3,
                                        input logic [19:0] s4, input logic [19:0] fill);
        return {tag, s1, s2, s3, s4, {8{fill}}};
    endfunction

    task automatic send_bits(input logic [255:0] f, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sync_i = (k < 16);
            sdin_i = f[255-k];
        end
    endtask

    // driver: pushes the expected items, sends the frame, checks flags
    task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1,
                              input logic [19:0] s2, input logic [19:0] s3,
                              input logic [19:0] s4, input logic [19:0] fill);
        logic exp_rl, exp_rr;
        if (tag[15] && tag[14] && tag[13]) exq.push_back({2'd0, s1[18:12], s2[19:4]});
        if (tag[12]) begin exq.push_back({2'd1, 5'd0, s3[19:2]}); exp_left  = s3[19:2]; end
        if (tag[11]) begin exq.push_back({2'd2, 5'd0, s4[19:2]}); exp_right = s4[19:2]; end
        exp_rl = tag[14] ? ~s1[11] : 1'b0;
        exp_rr = tag[14] ? ~s1[10] : 1'b0;
        send_bits(mk(tag, s1, s2, s3, s4, fill), 256);
        @(negedge clk);
        sync_i = 1'b0;
        sdin_i = 1'b0;
        check("R3 ready", 32'(codec_ready_o), 32'(tag[15]));
        check("R8 req_left", 32'(req_left_o), 32'(exp_rl));
        check("R8 req_right", 32'(req_right_o), 32'(exp_rr));
        check("R9 left held", 32'(left_pcm_o), 32'(exp_left));
        check("R9 right held", 32'(right_pcm_o), 32'(exp_right));
        check("R5 all strobes seen", 32'(exq.size()), 32'd0);
    endtask

    task automatic check_cleared(input string rq);
        check(rq, {20'd0, codec_ready_o, rd_stb_o, left_stb_o, right_stb_o,
                   req_left_o, req_right_o, 6'd0}, 32'd0);
        check(rq, {9'd0, rd_addr_o, rd_data_o}, 32'd0);
        check(rq, {14'd0, left_pcm_o}, 32'd0);
        check(rq, {14'd0, right_pcm_o}, 32'd0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_cleared("R1 reset state");

        // R1: noise with the marker low is ignored
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            sdin_i = 1'($urandom);
        end
        check_cleared("R1 idle before marker");

        // R2/R4/R6/R7/R8: everything valid, left requested, right not; ones in reserved slots (R9)
        send_frame(16'hF800, {1'b0, 7'h2A, 1'b0, 1'b1, 10'd0}, {16'hBEEF, 4'd0},
                   {18'h2A5A5, 2'd0}, {18'h15A5A, 2'd0}, 20'hFFFFF);

        // R5: codec not ready, marks set: samples still flow, no read
        send_frame(16'h7800, {1'b0, 7'h11, 1'b1, 1'b0, 10'd0}, {16'h1234, 4'd0},
                   {18'h00001, 2'd0}, {18'h20000, 2'd0}, 20'h00000);

        // R5/R8: slot1 mark clear -> no read, flags fall back; only right sample valid
        send_frame(16'hA800, {1'b0, 7'h7F, 1'b0, 1'b0, 10'd0}, {16'hAAAA, 4'd0},
                   {18'h3FFFF, 2'd0}, {18'h0F0F0, 2'd0}, 20'hA5A5A);

        // R5/R8: slot2 mark clear -> no read; right requested only
        send_frame(16'hD000, {1'b0, 7'h05, 1'b1, 1'b0, 10'd0}, {16'h5555, 4'd0},
                   {18'h12345, 2'd0}, {18'h2BCDE, 2'd0}, 20'h5A5A5);

        // R10: truncated frame (tag + 4 bits, marks set) then immediate realignment
        send_bits(mk(16'hF800, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF), 20);
        send_frame(16'hF800, {1'b0, 7'h33, 1'b1, 1'b1, 10'd0}, {16'hC0DE, 4'd0},
                   {18'h0ABCD, 2'd0}, {18'h3CAFE, 2'd0}, 20'h00000);

        // R1: reset in mid-frame clears stale state
        send_bits(mk(16'h8000, 20'd0, 20'd0, 20'd0, 20'd0, 20'd0), 100);
        @(negedge clk);
        sync_i = 1'b0;
        rst    = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_left  = '0;
        exp_right = '0;
        @(negedge clk);
        check_cleared("R1 mid-frame reset");

        send_frame(16'hF800, {1'b0, 7'h01, 1'b0, 1'b0, 10'd0}, {16'h0F0F, 4'd0},
                   {18'h11111, 2'd0}, {18'h22222, 2'd0}, 20'hFFFFF);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule